// File: doc/BRIEF.md
# Store Queue Drain with Late MESI Write Policy

This block holds a short first-in first-out queue of retired stores and empties it into a write-back data cache, one store at a time. Each store carries a byte address, a 64-bit data word and eight byte enables, so it can cover 1 to 8 bytes. When a store reaches the head of the queue, the block looks up the line in a tag and coherence-state array model. From that lookup it picks one of two paths. A cache-only write updates the data array through the cache write port. A writethrough sends the store to memory over a simple request/acknowledge bus port, and it also updates the cache when the line is present.

The write policy comes from the line state seen at the moment the store leaves the queue. It does not come from the state at the time the store was queued. Snoop requests read and change line states while stores wait, but they see only the state array, never the queued stores. A set port loads line tags and states into the model, standing in for the fill logic that lies outside this block. A probe port reads back the state of any line.

Top module: `stbuf_drain`

## Requirements
- R1: Stores drain in strict arrival order. `enq_ready` is low while DEPTH stores are held, and an `enq_valid` presented while `enq_ready` is low is dropped and never reaches either output port.
- R2: After reset the queue is empty, every line reads Invalid on the probe port, `enq_ready` is 1, and `bus_req` and `cwr_valid` are 0. States are encoded Invalid=0, Shared=1, Exclusive=2, Modified=3 on `set_state` and `probe_state`.
- R3: A drained store whose line is Exclusive pulses `cwr_valid` for one cycle with the store's address, data and enables. It makes no bus request, and the line becomes Modified.
- R4: A drained store whose line is Modified pulses `cwr_valid`, makes no bus request, and leaves the line Modified.
- R5: A drained store whose line is Shared pulses `cwr_valid` and then raises `bus_req` with the same address, data and enables. The line stays Shared.
- R6: A drained store whose line misses on tag, or matches with state Invalid, makes no cache write and raises `bus_req`. No line is allocated: the store's line still probes Invalid afterwards.
- R7: The policy uses the state at drain time. A line that is Exclusive when its store is queued, and is downgraded to Shared by a snoop before the store drains, is handled as Shared (writethrough).
- R8: While `bus_req` is high and `bus_ack` is low, the head store stays put. The bus address, data and enables hold steady, and no later store drains or writes the cache.
- R9: A snoop with `snoop_inv`=0 turns a Modified or Exclusive line Shared. A snoop with `snoop_inv`=1 turns the line Invalid. `snoop_hit` reports only a valid tag match in the state array, and a queued store to an uncached line does not make it 1.
- R10: No store drains in a cycle where `snoop_valid` or `set_valid` is high. The drain resumes once both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Store offered to the queue |
| enq_ready | output | 1 | Queue has room (low when full) |
| enq_addr | input | 32 | Store byte address |
| enq_data | input | 64 | Store data |
| enq_be | input | 8 | Store byte enables |
| snoop_valid | input | 1 | Snoop request this cycle |
| snoop_line | input | 27 | Line address being snooped |
| snoop_inv | input | 1 | 1 invalidates, 0 downgrades to Shared |
| snoop_hit | output | 1 | Snooped line valid in the state array |
| set_valid | input | 1 | Load a line tag and state |
| set_line | input | 27 | Line address to load |
| set_state | input | 2 | State to load |
| probe_line | input | 27 | Line address to read back |
| probe_state | output | 2 | State of the probed line (Invalid on tag miss) |
| cwr_valid | output | 1 | Cache data write strobe |
| cwr_addr | output | 32 | Cache write byte address |
| cwr_data | output | 64 | Cache write data |
| cwr_be | output | 8 | Cache write byte enables |
| bus_req | output | 1 | Writethrough request |
| bus_ack | input | 1 | Writethrough accepted |
| bus_addr | output | 32 | Writethrough byte address |
| bus_data | output | 64 | Writethrough data |
| bus_be | output | 8 | Writethrough byte enables |

## Verification
The hardest case to reach is a store that waits in the queue while a snoop changes the state of its line. With a healthy bus, a store drains one cycle after it is queued, which leaves no gap for a snoop to land in. The bench creates the gap on purpose. It holds back `bus_ack` so that an earlier miss blocks at the head. While that miss waits, the bench queues a store to an Exclusive line and a store to an uncached line behind it, then snoops both lines. After that it releases the bus and checks the write paths and the order of the bus writes.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic {
    DR_IDLE = 1'b0,
    DR_WAIT = 1'b1
  } drain_st_t;

  // A store must also go to memory when the line is absent, Invalid or Shared
  function automatic logic wt_needed(logic tag_hit, mesi_t s);
    return !tag_hit || (s == ST_I) || (s == ST_S);
  endfunction

  // State after a local cache-only write
  function automatic mesi_t after_store(mesi_t s);
    return (s == ST_E) ? ST_M : s;
  endfunction

  // State after a snoop that hits a valid line
  function automatic mesi_t after_snoop(mesi_t s, logic inv);
    if (inv) return ST_I;
    return ((s == ST_M) || (s == ST_E)) ? ST_S : s;
  endfunction

endpackage

// File: rtl/stq_fifo.sv
module stq_fifo #(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [AW-1:0]   push_addr,
  input  logic [DW-1:0]   push_data,
  input  logic [DW/8-1:0] push_be,
  input  logic            pop,
  output logic            full,
  output logic            head_valid,
  output logic [AW-1:0]   head_addr,
  output logic [DW-1:0]   head_data,
  output logic [DW/8-1:0] head_be
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int BEW = DW / 8;

  logic [AW-1:0]  addr_q [DEPTH];
  logic [DW-1:0]  data_q [DEPTH];
  logic [BEW-1:0] be_q   [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  count;

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (count == CW'(DEPTH));
  assign head_valid = (count != '0);
  assign head_addr  = addr_q[rd_ptr];
  assign head_data  = data_q[rd_ptr];
  assign head_be    = be_q[rd_ptr];

  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && head_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        addr_q[wr_ptr] <= push_addr;
        data_q[wr_ptr] <= push_data;
        be_q[wr_ptr]   <= push_be;
        wr_ptr         <= ptr_inc(wr_ptr);
      end
      if (do_pop) rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/line_state_array.sv
module line_state_array
  import stbuf_pkg::*;
#(
  parameter int LW    = 27,
  parameter int LINES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] lk_line,
  output logic          lk_tag_hit,
  output mesi_t         lk_state,
  input  logic          upd_valid,
  input  logic          snoop_valid,
  input  logic [LW-1:0] snoop_line,
  input  logic          snoop_inv,
  output logic          snoop_hit,
  input  logic          set_valid,
  input  logic [LW-1:0] set_line,
  input  mesi_t         set_state,
  input  logic [LW-1:0] probe_line,
  output mesi_t         probe_state
);
  localparam int IW = $clog2(LINES);
  localparam int TW = LW - IW;

  logic [TW-1:0] tag_q [LINES];
  mesi_t         st_q  [LINES];

  logic [IW-1:0] lk_idx, sn_idx, st_idx, pr_idx;
  assign lk_idx = lk_line[IW-1:0];
  assign sn_idx = snoop_line[IW-1:0];
  assign st_idx = set_line[IW-1:0];
  assign pr_idx = probe_line[IW-1:0];

  assign lk_tag_hit  = (tag_q[lk_idx] == lk_line[LW-1:IW]);
  assign lk_state    = st_q[lk_idx];
  assign snoop_hit   = snoop_valid && (tag_q[sn_idx] == snoop_line[LW-1:IW])
                       && (st_q[sn_idx] != ST_I);
  assign probe_state = (tag_q[pr_idx] == probe_line[LW-1:IW]) ? st_q[pr_idx] : ST_I;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= ST_I;
      end
    end else if (set_valid) begin
      tag_q[st_idx] <= set_line[LW-1:IW];
      st_q[st_idx]  <= set_state;
    end else if (snoop_hit) begin
      st_q[sn_idx] <= after_snoop(st_q[sn_idx], snoop_inv);
    end else if (upd_valid) begin
      st_q[lk_idx] <= after_store(st_q[lk_idx]);
    end
  end
endmodule

// File: rtl/stbuf_drain.sv
module stbuf_drain
  import stbuf_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int DEPTH      = 4,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           enq_valid,
  output logic                           enq_ready,
  input  logic [AW-1:0]                  enq_addr,
  input  logic [DW-1:0]                  enq_data,
  input  logic [DW/8-1:0]                enq_be,
  input  logic                           snoop_valid,
  input  logic [AW-$clog2(LINE_BYTES)-1:0] snoop_line,
  input  logic                           snoop_inv,
  output logic                           snoop_hit,
  input  logic                           set_valid,
  input  logic [AW-$clog2(LINE_BYTES)-1:0] set_line,
  input  logic [1:0]                     set_state,
  input  logic [AW-$clog2(LINE_BYTES)-1:0] probe_line,
  output logic [1:0]                     probe_state,
  output logic                           cwr_valid,
  output logic [AW-1:0]                  cwr_addr,
  output logic [DW-1:0]                  cwr_data,
  output logic [DW/8-1:0]                cwr_be,
  output logic                           bus_req,
  input  logic                           bus_ack,
  output logic [AW-1:0]                  bus_addr,
  output logic [DW-1:0]                  bus_data,
  output logic [DW/8-1:0]                bus_be
);
  localparam int OFF = $clog2(LINE_BYTES);
  localparam int LW  = AW - OFF;
  localparam int BEW = DW / 8;

  // named internal events, used by the bound checker
  logic           head_valid, q_full, pop;
  logic [AW-1:0]  head_addr;
  logic [DW-1:0]  head_data;
  logic [BEW-1:0] head_be;
  logic           lk_tag_hit, lk_hit, drain_go, drain_wt;
  mesi_t          lk_state, probe_st;
  drain_st_t      dr_q;

  stq_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (enq_valid),
    .push_addr  (enq_addr),
    .push_data  (enq_data),
    .push_be    (enq_be),
    .pop        (pop),
    .full       (q_full),
    .head_valid (head_valid),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .head_be    (head_be)
  );

  line_state_array #(.LW(LW), .LINES(LINES)) u_lines (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_line     (head_addr[AW-1:OFF]),
    .lk_tag_hit  (lk_tag_hit),
    .lk_state    (lk_state),
    .upd_valid   (drain_go && !drain_wt),
    .snoop_valid (snoop_valid),
    .snoop_line  (snoop_line),
    .snoop_inv   (snoop_inv),
    .snoop_hit   (snoop_hit),
    .set_valid   (set_valid),
    .set_line    (set_line),
    .set_state   (mesi_t'(set_state)),
    .probe_line  (probe_line),
    .probe_state (probe_st)
  );

  assign enq_ready   = !q_full;
  assign probe_state = probe_st;

  // decision is taken from the state read while the store is at the head
  assign lk_hit   = lk_tag_hit && (lk_state != ST_I);
  assign drain_go = (dr_q == DR_IDLE) && head_valid && !snoop_valid && !set_valid;
  assign drain_wt = wt_needed(lk_tag_hit, lk_state);
  assign pop      = (drain_go && !drain_wt) || ((dr_q == DR_WAIT) && bus_ack);

  assign cwr_valid = drain_go && lk_hit;
  assign cwr_addr  = head_addr;
  assign cwr_data  = head_data;
  assign cwr_be    = head_be;

  assign bus_req  = (dr_q == DR_WAIT);
  assign bus_addr = head_addr;
  assign bus_data = head_data;
  assign bus_be   = head_be;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_q <= DR_IDLE;
    end else begin
      case (dr_q)
        DR_IDLE: if (drain_go && drain_wt) dr_q <= DR_WAIT;
        DR_WAIT: if (bus_ack) dr_q <= DR_IDLE;
        default: dr_q <= DR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stbuf_drain_chk.sv
module stbuf_drain_chk
  import stbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            snoop_valid,
  input logic            set_valid,
  input logic            cwr_valid,
  input logic            bus_req,
  input logic            bus_ack,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_data,
  input logic [DW/8-1:0] bus_be,
  input logic            drain_go,
  input logic            lk_tag_hit,
  input mesi_t           lk_state
);
  a_r8_bus_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_data) && $stable(bus_be));

  a_r8_no_cache_write_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cwr_valid);

  a_r10_no_drain_on_snoop_or_set: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid || set_valid) |-> !cwr_valid);

  a_r5_shared_goes_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
    drain_go && lk_tag_hit && (lk_state == ST_S) |=> bus_req);

  a_r3_owned_line_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    drain_go && lk_tag_hit && ((lk_state == ST_E) || (lk_state == ST_M)) |=> !bus_req);

  a_r6_miss_goes_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
    drain_go && !lk_tag_hit |=> bus_req);
endmodule

bind stbuf_drain stbuf_drain_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .snoop_valid (snoop_valid),
  .set_valid   (set_valid),
  .cwr_valid   (cwr_valid),
  .bus_req     (bus_req),
  .bus_ack     (bus_ack),
  .bus_addr    (bus_addr),
  .bus_data    (bus_data),
  .bus_be      (bus_be),
  .drain_go    (drain_go),
  .lk_tag_hit  (lk_tag_hit),
  .lk_state    (lk_state)
);

// File: tb/stbuf_drain_test.sv
module stbuf_drain_test;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int LW = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0;
  logic enq_ready;
  logic [AW-1:0] enq_addr = '0;
  logic [DW-1:0] enq_data = '0;
  logic [7:0] enq_be = '0;
  logic snoop_valid = 1'b0;
  logic [LW-1:0] snoop_line = '0;
  logic snoop_inv = 1'b0;
  logic snoop_hit;
  logic set_valid = 1'b0;
  logic [LW-1:0] set_line = '0;
  logic [1:0] set_state = '0;
  logic [LW-1:0] probe_line = '0;
  logic [1:0] probe_state;
  logic cwr_valid;
  logic [AW-1:0] cwr_addr;
  logic [DW-1:0] cwr_data;
  logic [7:0] cwr_be;
  logic bus_req;
  logic bus_ack = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic [7:0] bus_be;

  always #10 clk = ~clk;

  stbuf_drain uut (.*);

  int checks = 0;
  int errors = 0;
  int cwr_cnt = 0;
  int bus_cnt = 0;
  bit ack_en = 1'b1;
  logic [AW-1:0] bus_log [64];
  logic [AW-1:0] last_cwr_addr, last_bus_addr;
  logic [DW-1:0] last_cwr_data, last_bus_data;
  logic [7:0] last_bus_be;

  // bus responder: one-cycle acknowledge, driven just after the edge
  always @(posedge clk) begin
    #1;
    bus_ack = ack_en && bus_req && !bus_ack;
  end

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (cwr_valid) begin
        cwr_cnt++;
        last_cwr_addr = cwr_addr;
        last_cwr_data = cwr_data;
      end
      if (bus_req && bus_ack) begin
        bus_log[bus_cnt % 64] = bus_addr;
        last_bus_addr = bus_addr;
        last_bus_data = bus_data;
        last_bus_be   = bus_be;
        bus_cnt++;
      end
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] mk_line(int tag, int idx);
    return LW'((tag << 4) | (idx & 15));
  endfunction

  function automatic logic [AW-1:0] mk_addr(logic [LW-1:0] ln, int off);
    return {ln, 5'(off)};
  endfunction

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load_line(logic [LW-1:0] ln, logic [1:0] s);
    @(posedge clk); #2;
    set_valid = 1'b1; set_line = ln; set_state = s;
    @(posedge clk); #2;
    set_valid = 1'b0;
  endtask

  task automatic push(logic [AW-1:0] a, logic [DW-1:0] d, logic [7:0] be);
    @(posedge clk); #2;
    enq_valid = 1'b1; enq_addr = a; enq_data = d; enq_be = be;
    @(posedge clk); #2;
    enq_valid = 1'b0;
  endtask

  task automatic do_snoop(logic [LW-1:0] ln, logic inv, output logic hit);
    @(posedge clk); #2;
    snoop_valid = 1'b1; snoop_line = ln; snoop_inv = inv;
    @(negedge clk);
    hit = snoop_hit;
    @(posedge clk); #2;
    snoop_valid = 1'b0;
  endtask

  task automatic probe(logic [LW-1:0] ln, output logic [1:0] s);
    probe_line = ln;
    @(negedge clk);
    s = probe_state;
  endtask

  // {init[6:5], same_tag[4], exp_cwr[3], exp_bus[2], exp_state[1:0]}
  // states: I=0 S=1 E=2 M=3
  localparam logic [6:0] VEC [6] = '{
    {2'd0, 1'b1, 1'b0, 1'b1, 2'd0},   // R6 invalid line
    {2'd1, 1'b1, 1'b1, 1'b1, 2'd1},   // R5 shared line
    {2'd2, 1'b1, 1'b1, 1'b0, 2'd3},   // R3 exclusive line
    {2'd3, 1'b1, 1'b1, 1'b0, 2'd3},   // R4 modified line
    {2'd2, 1'b0, 1'b0, 1'b1, 2'd0},   // R6 tag miss
    {2'd1, 1'b1, 1'b1, 1'b1, 2'd1}    // R5 shared, other enables
  };

  function automatic string req_of(logic [6:0] v);
    if (!v[4] || v[6:5] == 2'd0) return "R6";
    case (v[6:5])
      2'd1: return "R5";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] s;
    logic h;
    int c0, b0;
    logic [LW-1:0] la, lb, lc, ld;

    cycles(3);
    rst_n = 1'b1;
    cycles(1);

    // R2 reset state
    @(negedge clk);
    chk("R2", "enq_ready", enq_ready, 1);
    chk("R2", "bus_req", bus_req, 0);
    chk("R2", "cwr_valid", cwr_valid, 0);
    probe(mk_line(0, 3), s);
    chk("R2", "probe after reset", s, 0);

    // vector table: one store per line state
    for (int i = 0; i < 6; i++) begin
      logic [6:0] v;
      logic [LW-1:0] sl;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [7:0] be;
      v  = VEC[i];
      sl = mk_line(16'h1A5 + i, i + 1);
      a  = mk_addr(sl, (i * 8) % 32);
      d  = 64'hC0DE_0000_0000_0000 + 64'(i * 17);
      be = 8'hFF >> i;
      load_line(v[4] ? sl : mk_line(16'h3F0 + i, i + 1), v[6:5]);
      c0 = cwr_cnt; b0 = bus_cnt;
      push(a, d, be);
      cycles(6);
      chk(req_of(v), "cache writes", 64'(cwr_cnt - c0), 64'(v[3]));
      chk(req_of(v), "bus writes", 64'(bus_cnt - b0), 64'(v[2]));
      probe(sl, s);
      chk(req_of(v), "line state after drain", s, v[1:0]);
      if (v[3]) chk(req_of(v), "cache write data", last_cwr_data, d);
      if (v[2]) begin
        chk(req_of(v), "bus addr", last_bus_addr, a);
        chk(req_of(v), "bus data", last_bus_data, d);
        chk(req_of(v), "bus enables", last_bus_be, be);
      end
    end

    // R7 / R8 / R9: stores held behind a stalled writethrough while snoops land
    ack_en = 1'b0;
    lb = mk_line(16'h222, 8);
    la = mk_line(16'h111, 9);
    lc = mk_line(16'h333, 10);
    c0 = cwr_cnt; b0 = bus_cnt;
    push(mk_addr(lb, 0), 64'hB, 8'h01);
    load_line(la, 2'd2);
    push(mk_addr(la, 8), 64'hA, 8'h0F);
    push(mk_addr(lc, 16), 64'hC, 8'hF0);
    cycles(3);
    @(negedge clk);
    chk("R8", "bus_req held without ack", bus_req, 1);
    chk("R8", "bus addr held on head", bus_addr, mk_addr(lb, 0));
    chk("R8", "no later store drained", 64'(cwr_cnt - c0), 0);
    do_snoop(la, 1'b0, h);
    chk("R9", "snoop hits cached line", h, 1);
    probe(la, s);
    chk("R9", "exclusive downgraded to shared", s, 1);
    do_snoop(lc, 1'b1, h);
    chk("R9", "queued store invisible to snoop", h, 0);
    ack_en = 1'b1;
    cycles(12);
    chk("R7", "bus writes after release", 64'(bus_cnt - b0), 3);
    chk("R1", "first bus write in order", bus_log[b0 % 64], mk_addr(lb, 0));
    chk("R7", "downgraded store went to bus", bus_log[(b0 + 1) % 64], mk_addr(la, 8));
    chk("R1", "third bus write in order", bus_log[(b0 + 2) % 64], mk_addr(lc, 16));
    chk("R7", "downgraded store also wrote cache", 64'(cwr_cnt - c0), 1);
    chk("R7", "cache write address", last_cwr_addr, mk_addr(la, 8));
    probe(la, s);
    chk("R7", "line stays shared", s, 1);

    // R9 modified line: share then invalidate
    ld = mk_line(16'h444, 13);
    load_line(ld, 2'd3);
    do_snoop(ld, 1'b0, h);
    probe(ld, s);
    chk("R9", "modified downgraded to shared", s, 1);
    do_snoop(ld, 1'b1, h);
    probe(ld, s);
    chk("R9", "invalidate snoop", s, 0);

    // R10: drain waits while a snoop is present
    ld = mk_line(16'h555, 11);
    load_line(ld, 2'd3);
    c0 = cwr_cnt;
    @(posedge clk); #2;
    snoop_valid = 1'b1; snoop_line = mk_line(16'h666, 12); snoop_inv = 1'b0;
    enq_valid = 1'b1; enq_addr = mk_addr(ld, 0); enq_data = 64'hD; enq_be = 8'hFF;
    @(posedge clk); #2;
    enq_valid = 1'b0;
    cycles(3);
    chk("R10", "no drain during snoop", 64'(cwr_cnt - c0), 0);
    snoop_valid = 1'b0;
    cycles(3);
    chk("R10", "drain after snoop ends", 64'(cwr_cnt - c0), 1);

    // R1: full queue backpressure and dropped push
    ack_en = 1'b0;
    b0 = bus_cnt;
    for (int k = 0; k < 4; k++) push(mk_addr(mk_line(16'h700 + k, 14), 0), 64'(k), 8'h01);
    @(negedge clk);
    chk("R1", "enq_ready low when full", enq_ready, 0);
    push(mk_addr(mk_line(16'h7FF, 14), 0), 64'hEE, 8'h01);
    ack_en = 1'b1;
    cycles(20);
    chk("R1", "only queued stores reach bus", 64'(bus_cnt - b0), 4);
    for (int k = 0; k < 4; k++)
      chk("R1", "fifo order", bus_log[(b0 + k) % 64], mk_addr(mk_line(16'h700 + k, 14), 0));
    @(negedge clk);
    chk("R1", "enq_ready back after drain", enq_ready, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule